// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor whose datapath shares one ALU and one memory across the steps of an instruction. It is a Moore machine. Every instruction passes through a fetch step and a decode step. After decode the machine branches on the 6-bit opcode into a short chain of steps for loads and stores, for register arithmetic, for a conditional branch or for an unconditional jump. Each state drives a fixed set of select and write-enable levels into the datapath, so an instruction takes three to five cycles, depending on its kind.

Two faults divert the machine into a trap state. An opcode that the decoder does not know causes one. An arithmetic overflow reported while a register-arithmetic result is being computed causes the other. A trap state stores the address of the faulting instruction and a cause code, loads the PC with the fixed exception vector, and returns to fetch. The overflow trap also skips the register write that would otherwise follow. The current state number is brought out so that the surrounding logic and the bench can observe the sequence.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While reset is held (rst_n low, asynchronous), cur_state is 0 and the outputs show the fetch pattern of R2.
- R2: State 0 (fetch) drives mem_rd=1, addr_sel_alu=0, ir_ld=1, opa_sel=0, opb_sel=01, alu_mode=00, pc_sel=00 and pc_ld=1. It always moves to state 1.
- R3: State 1 (decode) drives opa_sel=0, opb_sel=11 and alu_mode=00. It moves to state 2 for opcode 100011 (load) or 101011 (store), to state 6 for 000000 (register arithmetic), to state 8 for 000100 (branch) and to state 9 for 000010 (jump).
- R4: State 2 drives opa_sel=1, opb_sel=10 and alu_mode=00, then moves to state 3 for a load and to state 5 for a store. State 3 drives mem_rd=1 and addr_sel_alu=1, then moves to state 4. State 4 drives rf_wr=1, wb_sel_mdr=1 and dst_sel_rd=0, then moves to state 0. State 5 drives mem_wr=1 and addr_sel_alu=1, then moves to state 0.
- R5: State 6 drives opa_sel=1, opb_sel=00 and alu_mode=10, and moves to state 7 when overflow is low. State 7 drives rf_wr=1, wb_sel_mdr=0 and dst_sel_rd=1, then moves to state 0.
- R6: State 8 drives opa_sel=1, opb_sel=00, alu_mode=01, pc_ld_if_zero=1 and pc_sel=01, then moves to state 0.
- R7: State 9 drives pc_ld=1 and pc_sel=10, then moves to state 0.
- R8: Any other opcode in state 1 leads to state 10. State 10 drives cause_ld=1, cause_val=0, epc_ld=1, opa_sel=0, opb_sel=01, alu_mode=01, pc_ld=1 and pc_sel=11, then moves to state 0.
- R9: When overflow is high in state 6, the next state is 11 instead of 7. State 11 drives the pattern of state 10, except that cause_val=1. No register write takes place for that instruction. The overflow input has no effect in any other state.
- R10: Every single-bit output that is not listed for the current state is 0, and every 2-bit select that is not listed is 00.
- R11: From one fetch to the next, an instruction takes the following number of cycles: load 5, store 4, register arithmetic 4, branch 3, jump 3, undefined opcode 3, and register arithmetic with overflow 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the held instruction |
| overflow | input | 1 | ALU overflow flag from the datapath |
| addr_sel_alu | output | 1 | Memory address taken from the ALU result register instead of the PC |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_ld | output | 1 | Load the instruction register |
| wb_sel_mdr | output | 1 | Register write data taken from the memory data register |
| dst_sel_rd | output | 1 | Write-register number taken from bits 15..11 |
| rf_wr | output | 1 | Register file write |
| opa_sel | output | 1 | ALU operand A is the A register instead of the PC |
| opb_sel | output | 2 | ALU operand B: 00 B register, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 function field decides |
| pc_sel | output | 2 | PC source: 00 ALU, 01 stored target, 10 jump address, 11 exception vector |
| pc_ld | output | 1 | Unconditional PC write |
| pc_ld_if_zero | output | 1 | PC write when the ALU zero flag is set |
| epc_ld | output | 1 | Write the exception PC register |
| cause_ld | output | 1 | Write the cause register |
| cause_val | output | 1 | Cause code: 0 undefined opcode, 1 overflow |
| cur_state | output | 4 | Current state number |

## Verification
In state 6, the overflow check and the normal hand-off to the write-back state are decided in the same cycle. Overflow takes priority, and with it the register write is suppressed. The bench drives every one of the 64 opcodes twice: once with overflow low, and once with overflow held high for the whole instruction. So overflow meets every state. The bench then judges the full state sequence and the outputs in every cycle. The overflow trap must appear only after state 6 of a register-arithmetic instruction, and every other path must follow its usual course, including the undefined-opcode trap taken from decode while overflow is high.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MRD    = 4'd3,
    S_MWB    = 4'd4,
    S_MWR    = 4'd5,
    S_EXEC   = 4'd6,
    S_RWB    = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9,
    S_XUNDEF = 4'd10,
    S_XOVF   = 4'd11
  } state_e;

  typedef enum logic [2:0] {
    C_LOAD, C_STORE, C_ALU, C_BR, C_JMP, C_BAD
  } opclass_e;

  localparam logic [1:0] OPB_REG    = 2'b00;
  localparam logic [1:0] OPB_FOUR   = 2'b01;
  localparam logic [1:0] OPB_IMM    = 2'b10;
  localparam logic [1:0] OPB_IMM_SH = 2'b11;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;

  localparam logic [1:0] PC_ALU = 2'b00;
  localparam logic [1:0] PC_TGT = 2'b01;
  localparam logic [1:0] PC_JMP = 2'b10;
  localparam logic [1:0] PC_VEC = 2'b11;

  typedef struct packed {
    logic       addr_sel_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       wb_sel_mdr;
    logic       dst_sel_rd;
    logic       rf_wr;
    logic       opa_sel;
    logic [1:0] opb_sel;
    logic [1:0] alu_mode;
    logic [1:0] pc_sel;
    logic       pc_ld;
    logic       pc_ld_if_zero;
    logic       epc_ld;
    logic       cause_ld;
    logic       cause_val;
  } ctrl_t;

  // Both trap states share one pattern; only the cause code differs.
  function automatic ctrl_t trap_pattern(input logic code);
    ctrl_t c;
    c           = '0;
    c.cause_ld  = 1'b1;
    c.cause_val = code;
    c.epc_ld    = 1'b1;
    c.opa_sel   = 1'b0;
    c.opb_sel   = OPB_FOUR;
    c.alu_mode  = ALU_SUB;
    c.pc_ld     = 1'b1;
    c.pc_sel    = PC_VEC;
    return c;
  endfunction

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
  import mc_ctrl_pkg::*;
#(
  parameter int                OP_W   = 6,
  parameter logic [OP_W-1:0]   OP_ALU = 6'b000000,
  parameter logic [OP_W-1:0]   OP_LD  = 6'b100011,
  parameter logic [OP_W-1:0]   OP_ST  = 6'b101011,
  parameter logic [OP_W-1:0]   OP_BR  = 6'b000100,
  parameter logic [OP_W-1:0]   OP_JMP = 6'b000010
) (
  input  logic [OP_W-1:0] opcode,
  output opclass_e        cls
);
  always_comb begin
    if      (opcode == OP_ALU) cls = C_ALU;
    else if (opcode == OP_LD)  cls = C_LOAD;
    else if (opcode == OP_ST)  cls = C_STORE;
    else if (opcode == OP_BR)  cls = C_BR;
    else if (opcode == OP_JMP) cls = C_JMP;
    else                       cls = C_BAD;
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e   cur,
  input  opclass_e cls,
  input  logic     overflow,
  output state_e   nxt
);
  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (cls)
          C_LOAD, C_STORE: nxt = S_MADDR;
          C_ALU:           nxt = S_EXEC;
          C_BR:            nxt = S_BRANCH;
          C_JMP:           nxt = S_JUMP;
          default:         nxt = S_XUNDEF;
        endcase
      end
      S_MADDR:  nxt = (cls == C_STORE) ? S_MWR : S_MRD;
      S_MRD:    nxt = S_MWB;
      S_EXEC:   nxt = overflow ? S_XOVF : S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH: begin
        ctl.mem_rd   = 1'b1;
        ctl.ir_ld    = 1'b1;
        ctl.opb_sel  = OPB_FOUR;
        ctl.alu_mode = ALU_ADD;
        ctl.pc_sel   = PC_ALU;
        ctl.pc_ld    = 1'b1;
      end
      S_DECODE: begin
        ctl.opb_sel  = OPB_IMM_SH;
        ctl.alu_mode = ALU_ADD;
      end
      S_MADDR: begin
        ctl.opa_sel  = 1'b1;
        ctl.opb_sel  = OPB_IMM;
        ctl.alu_mode = ALU_ADD;
      end
      S_MRD: begin
        ctl.mem_rd       = 1'b1;
        ctl.addr_sel_alu = 1'b1;
      end
      S_MWB: begin
        ctl.rf_wr      = 1'b1;
        ctl.wb_sel_mdr = 1'b1;
      end
      S_MWR: begin
        ctl.mem_wr       = 1'b1;
        ctl.addr_sel_alu = 1'b1;
      end
      S_EXEC: begin
        ctl.opa_sel  = 1'b1;
        ctl.opb_sel  = OPB_REG;
        ctl.alu_mode = ALU_FUNCT;
      end
      S_RWB: begin
        ctl.rf_wr      = 1'b1;
        ctl.dst_sel_rd = 1'b1;
      end
      S_BRANCH: begin
        ctl.opa_sel       = 1'b1;
        ctl.opb_sel       = OPB_REG;
        ctl.alu_mode      = ALU_SUB;
        ctl.pc_ld_if_zero = 1'b1;
        ctl.pc_sel        = PC_TGT;
      end
      S_JUMP: begin
        ctl.pc_ld  = 1'b1;
        ctl.pc_sel = PC_JMP;
      end
      S_XUNDEF: ctl = trap_pattern(1'b0);
      S_XOVF:   ctl = trap_pattern(1'b1);
      default:  ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W   = 6,
  parameter logic [OP_W-1:0] OP_ALU = 6'b000000,
  parameter logic [OP_W-1:0] OP_LD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_ST  = 6'b101011,
  parameter logic [OP_W-1:0] OP_BR  = 6'b000100,
  parameter logic [OP_W-1:0] OP_JMP = 6'b000010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            overflow,
  output logic            addr_sel_alu,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_ld,
  output logic            wb_sel_mdr,
  output logic            dst_sel_rd,
  output logic            rf_wr,
  output logic            opa_sel,
  output logic [1:0]      opb_sel,
  output logic [1:0]      alu_mode,
  output logic [1:0]      pc_sel,
  output logic            pc_ld,
  output logic            pc_ld_if_zero,
  output logic            epc_ld,
  output logic            cause_ld,
  output logic            cause_val,
  output logic [ST_W-1:0] cur_state
);
  state_e   state_q;
  state_e   state_d;
  opclass_e cls;
  ctrl_t    ctl;

  // Named events for the checker
  logic op_illegal;
  logic ovf_hit;
  logic instr_done;

  mc_op_class #(
    .OP_W(OP_W), .OP_ALU(OP_ALU), .OP_LD(OP_LD),
    .OP_ST(OP_ST), .OP_BR(OP_BR), .OP_JMP(OP_JMP)
  ) u_class (
    .opcode (opcode),
    .cls    (cls)
  );

  mc_next_state u_next (
    .cur      (state_q),
    .cls      (cls),
    .overflow (overflow),
    .nxt      (state_d)
  );

  mc_out_decode u_out (
    .cur (state_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_FETCH;
    else        state_q <= state_d;
  end

  assign op_illegal = (cls == C_BAD);
  assign ovf_hit    = (state_q == S_EXEC) && overflow;
  assign instr_done = (state_d == S_FETCH);

  assign addr_sel_alu  = ctl.addr_sel_alu;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign ir_ld         = ctl.ir_ld;
  assign wb_sel_mdr    = ctl.wb_sel_mdr;
  assign dst_sel_rd    = ctl.dst_sel_rd;
  assign rf_wr         = ctl.rf_wr;
  assign opa_sel       = ctl.opa_sel;
  assign opb_sel       = ctl.opb_sel;
  assign alu_mode      = ctl.alu_mode;
  assign pc_sel        = ctl.pc_sel;
  assign pc_ld         = ctl.pc_ld;
  assign pc_ld_if_zero = ctl.pc_ld_if_zero;
  assign epc_ld        = ctl.epc_ld;
  assign cause_ld      = ctl.cause_ld;
  assign cause_val     = ctl.cause_val;
  assign cur_state     = state_q;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] st,
  input logic       overflow,
  input logic       op_illegal,
  input logic       ovf_hit,
  input logic       instr_done,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       rf_wr,
  input logic       pc_ld,
  input logic       pc_ld_if_zero,
  input logic [1:0] pc_sel,
  input logic       epc_ld,
  input logic       cause_ld,
  input logic       cause_val
);
  a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
    st == 4'd0 |=> st == 4'd1);

  a_r3_illegal_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd1) && op_illegal |=> st == 4'd10);

  a_r4_load_chain: assert property (@(posedge clk) disable iff (!rst_n)
    st == 4'd3 |=> st == 4'd4);

  a_r5_exec_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd6) && !overflow |=> st == 4'd7);

  a_r9_overflow_trap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> st == 4'd11);

  a_r9_no_write_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
    st == 4'd11 |-> !rf_wr && cause_val);

  a_r8_trap_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd10) || (st == 4'd11) |=> st == 4'd0);

  a_r8_cause_with_epc: assert property (@(posedge clk) disable iff (!rst_n)
    cause_ld |-> epc_ld && pc_ld && (pc_sel == 2'b11));

  a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, rf_wr}));

  a_r6_cond_target: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_if_zero |-> (pc_sel == 2'b01) && !pc_ld);

  a_r11_done_from_tail: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> (st != 4'd0) && (st != 4'd1) && (st != 4'd2) && (st != 4'd3) && (st != 4'd6));
endmodule

bind mc_ctrl_fsm mc_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st            (cur_state),
  .overflow      (overflow),
  .op_illegal    (op_illegal),
  .ovf_hit       (ovf_hit),
  .instr_done    (instr_done),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .rf_wr         (rf_wr),
  .pc_ld         (pc_ld),
  .pc_ld_if_zero (pc_ld_if_zero),
  .pc_sel        (pc_sel),
  .epc_ld        (epc_ld),
  .cause_ld      (cause_ld),
  .cause_val     (cause_val)
);

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic       overflow = 1'b0;
  logic addr_sel_alu, mem_rd, mem_wr, ir_ld, wb_sel_mdr, dst_sel_rd, rf_wr, opa_sel;
  logic [1:0] opb_sel, alu_mode, pc_sel;
  logic pc_ld, pc_ld_if_zero, epc_ld, cause_ld, cause_val;
  logic [3:0] cur_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_ctrl_fsm dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .overflow(overflow),
    .addr_sel_alu(addr_sel_alu), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
    .wb_sel_mdr(wb_sel_mdr), .dst_sel_rd(dst_sel_rd), .rf_wr(rf_wr), .opa_sel(opa_sel),
    .opb_sel(opb_sel), .alu_mode(alu_mode), .pc_sel(pc_sel), .pc_ld(pc_ld),
    .pc_ld_if_zero(pc_ld_if_zero), .epc_ld(epc_ld), .cause_ld(cause_ld),
    .cause_val(cause_val), .cur_state(cur_state)
  );

  // Observed outputs, packed as
  // {addr,rd,wr,ir,mdr,rd_dst,rfw,opa,opb[2],alu[2],pcs[2],pcl,pcz,epc,cl,cv}
  function automatic logic [18:0] observed();
    return {addr_sel_alu, mem_rd, mem_wr, ir_ld, wb_sel_mdr, dst_sel_rd, rf_wr,
            opa_sel, opb_sel, alu_mode, pc_sel, pc_ld, pc_ld_if_zero, epc_ld,
            cause_ld, cause_val};
  endfunction

  // Expected pattern per state, taken from the requirement text.
  function automatic logic [18:0] expect_ctl(input int s);
    logic a, r, w, ir, m, d, f, oa, pl, pz, e, cl, cv;
    logic [1:0] ob, am, ps;
    {a, r, w, ir, m, d, f, oa, pl, pz, e, cl, cv} = '0;
    ob = 2'd0; am = 2'd0; ps = 2'd0;
    if (s == 0) begin r = 1; ir = 1; ob = 2'd1; pl = 1; end
    if (s == 1) ob = 2'd3;
    if (s == 2) begin oa = 1; ob = 2'd2; end
    if (s == 3) begin r = 1; a = 1; end
    if (s == 4) begin f = 1; m = 1; end
    if (s == 5) begin w = 1; a = 1; end
    if (s == 6) begin oa = 1; am = 2'd2; end
    if (s == 7) begin f = 1; d = 1; end
    if (s == 8) begin oa = 1; am = 2'd1; pz = 1; ps = 2'd1; end
    if (s == 9) begin pl = 1; ps = 2'd2; end
    if (s == 10 || s == 11) begin
      cl = 1; e = 1; ob = 2'd1; am = 2'd1; pl = 1; ps = 2'd3;
      cv = (s == 11);
    end
    return {a, r, w, ir, m, d, f, oa, ob, am, ps, pl, pz, e, cl, cv};
  endfunction

  function automatic string req_of(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4, 5: return "R4";
      6, 7: return "R5";
      8: return "R6";
      9: return "R7";
      10: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_state(input int exp_s, input string req);
    checks++;
    if (cur_state !== exp_s[3:0]) begin
      errors++;
      $display("FAIL %s state op=%b ovf=%b actual=%0d expected=%0d",
               req, opcode, overflow, cur_state, exp_s);
    end
    checks++;
    if (observed() !== expect_ctl(exp_s)) begin
      errors++;
      $display("FAIL %s/R10 outputs state=%0d actual=%b expected=%b",
               req, exp_s, observed(), expect_ctl(exp_s));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seq[6];
    int n;
    // R1: the reset state
    repeat (3) @(negedge clk);
    opcode = 6'b100011;
    @(negedge clk);
    check_state(0, "R1");
    rst_n = 1'b1;

    for (int op = 0; op < 64; op++) begin
      for (int ov = 0; ov < 2; ov++) begin
        opcode   = op[5:0];
        overflow = ov[0];
        seq[0] = 0; seq[1] = 1; n = 3;
        if (op == 35)      begin seq[2] = 2; seq[3] = 3; seq[4] = 4; n = 5; end
        else if (op == 43) begin seq[2] = 2; seq[3] = 5; n = 4; end
        else if (op == 0)  begin seq[2] = 6; seq[3] = (ov == 1) ? 11 : 7; n = 4; end
        else if (op == 4)  seq[2] = 8;
        else if (op == 2)  seq[2] = 9;
        else               seq[2] = 10;
        for (int k = 0; k < n; k++) begin
          if (k > 0) @(negedge clk);
          check_state(seq[k], (ov == 1 && k > 1) ? "R9" : req_of(seq[k]));
        end
        @(negedge clk);
        // R11: back at fetch exactly n cycles after this instruction began
        checks++;
        if (cur_state !== 4'd0) begin
          errors++;
          $display("FAIL R11 length op=%b ovf=%0d actual_state=%0d expected=0 after %0d cycles",
                   op[5:0], ov, cur_state, n);
        end
      end
    end

    // R1: asynchronous reset in the middle of a load
    opcode = 6'b100011; overflow = 1'b0;
    repeat (3) @(negedge clk);
    check_state(3, "R4");
    rst_n = 1'b0;
    #1;
    check_state(0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    check_state(0, "R1");
    @(negedge clk);
    check_state(1, "R2");

    finish_run();
  end
endmodule